// File: doc/BRIEF.md
# Rolling Activate-Window Limiter

This block enforces a power budget on row activates. A scheduler or refresh engine reports every activate it issues through a single strobe and a rank index. For each rank, the block remembers which of the last `WINDOW` memory cycles carried an activate to that rank. It drops that rank's permit while the rank has used up its budget of `ACT_BUDGET` activates inside the sliding window. Refreshes are reported through the same strobe, so they count as activates.

The history of each rank is a shift register `WINDOW` bits long. A new activate enters at the top bit. The history moves one place toward bit 0 every cycle, and a bit that leaves bit 0 has expired. A running count of the set bits is kept next to each register, so the permit is a narrow compare and not a population count over the whole window. When `WINDOW` is zero, the block records nothing and every permit stays high. The permits are registered and are valid from the clock edge that records the activate.

Top module: `act_win_limiter`

## Requirements
- R1: A synchronous active-high reset clears every rank's history and count, and every permit reads 1 from the first edge at which reset is sampled high.
- R2: An activate strobe with rank index r is recorded against rank r only. The index is an unsigned binary rank number, and an index of `NUM_RANKS` or more is ignored.
- R3: A rank's permit is 0 exactly when at least `ACT_BUDGET` (default 4) of its recorded activates are still inside the window. The permit goes low at the clock edge that records the activate that reaches the budget.
- R4: An activate recorded at clock edge t counts for the edges t through t+WINDOW-1 and has expired at edge t+WINDOW.
- R5: An activate reported while the rank's permit is 0 is still recorded and extends the time the permit stays low.
- R6: If an activate to a rank is recorded at the same edge at which an older activate of that rank expires, the expiry is applied first. The count is then unchanged and stays equal to the number of activates held in the history.
- R7: With `WINDOW` = 0, no activate is recorded and every permit is 1 at all times.
- R8: The ranks are independent. Activates to one rank never change the permit of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory controller clock |
| rst | input | 1 | Synchronous reset, active high |
| act_valid | input | 1 | One activate (request or refresh) issued this cycle |
| act_rank | input | RANK_W | Rank index of the activate |
| act_permit | output | NUM_RANKS | Per-rank permission to issue another activate |

## Verification
The bench targets the following corner cases:

- **Expiry timing.** An activate that ages out one cycle early or one cycle late would show up as a permit that rises one cycle off from the reference.
- **Blocked activates.** An activate reported while the rank is blocked must still be recorded. A design that drops it would release the rank early.
- **Expiry and insertion in the same cycle.** If an expiry and a new activate land in the same cycle and the design applies them in the wrong order, the count drifts away from the history. The permit then sticks low or rises too early.
- **Other cases.** The bench also covers an activate aimed at one rank that leaks into a neighbour, and a zero-length window that still throttles.

// File: rtl/act_win_pkg.sv
package act_win_pkg;

  // History length: a disabled window still gets a 1-bit placeholder.
  function automatic int hist_width(input int window);
    return (window < 1) ? 1 : window;
  endfunction

  // Count must hold every bit of the history set at once.
  function automatic int count_width(input int window);
    return $clog2(hist_width(window) + 1);
  endfunction

  function automatic int index_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/act_win_decode.sv
module act_win_decode #(
  parameter int NUM_RANKS = 4,
  parameter int RANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 act_valid,
  input  logic [RANK_W-1:0]    act_rank,
  output logic [NUM_RANKS-1:0] rank_hit
);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_hit
    assign rank_hit[r] = act_valid && (32'(act_rank) == r);
  end

  // R2
  single_rank_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rank_hit));

  // R2
  hit_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (rank_hit != '0) |-> act_valid);

endmodule

// File: rtl/act_win_rank.sv
module act_win_rank #(
  parameter int WINDOW     = 16,
  parameter int ACT_BUDGET = 4,
  parameter int HIST_W     = 16,
  parameter int CNT_W      = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  output logic permit
);

  if (WINDOW == 0) begin : g_off
    // Limiting disabled: nothing is tracked.
    assign permit = 1'b1;
  end else begin : g_on
    logic [HIST_W-1:0] hist_q, hist_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              permit_q, permit_d;

    always_comb begin
      // Age the history first, then place the new activate at the top.
      hist_d   = (hist_q >> 1) | ({{(HIST_W-1){1'b0}}, act} << (HIST_W-1));
      cnt_d    = cnt_q - CNT_W'(hist_q[0]) + CNT_W'(act);
      permit_d = (32'(cnt_d) < ACT_BUDGET);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        hist_q   <= '0;
        cnt_q    <= '0;
        permit_q <= 1'b1;
      end else begin
        hist_q   <= hist_d;
        cnt_q    <= cnt_d;
        permit_q <= permit_d;
      end
    end

    assign permit = permit_q;

    // R6
    count_matches_hist_chk: assert property (@(posedge clk) disable iff (rst)
      32'(cnt_q) == $countones(hist_q));

    // R5
    act_recorded_chk: assert property (@(posedge clk) disable iff (rst)
      act |=> hist_q[HIST_W-1]);

    // R4
    no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
      !act |=> !hist_q[HIST_W-1]);

    // R4
    expire_dec_chk: assert property (@(posedge clk) disable iff (rst)
      (hist_q[0] && !act) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R3
    permit_budget_chk: assert property (@(posedge clk) disable iff (rst)
      permit_q == (32'(cnt_q) < ACT_BUDGET));
  end

endmodule

// File: rtl/act_win_limiter.sv
module act_win_limiter
  import act_win_pkg::*;
#(
  parameter int NUM_RANKS  = 4,
  parameter int WINDOW     = 16,
  parameter int ACT_BUDGET = 4,
  parameter int RANK_W     = index_width(NUM_RANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 act_valid,
  input  logic [RANK_W-1:0]    act_rank,
  output logic [NUM_RANKS-1:0] act_permit
);

  localparam int HIST_W = hist_width(WINDOW);
  localparam int CNT_W  = count_width(WINDOW);

  initial begin
    window_range_chk: assert (WINDOW >= 0 && WINDOW <= 62);
  end

  logic [NUM_RANKS-1:0] rank_hit;

  act_win_decode #(
    .NUM_RANKS (NUM_RANKS),
    .RANK_W    (RANK_W)
  ) u_decode (
    .clk       (clk),
    .rst       (rst),
    .act_valid (act_valid),
    .act_rank  (act_rank),
    .rank_hit  (rank_hit)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    act_win_rank #(
      .WINDOW     (WINDOW),
      .ACT_BUDGET (ACT_BUDGET),
      .HIST_W     (HIST_W),
      .CNT_W      (CNT_W)
    ) u_rank (
      .clk    (clk),
      .rst    (rst),
      .act    (rank_hit[r]),
      .permit (act_permit[r])
    );
  end

  // R8
  quiet_permit_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !act_valid |=> ($past(act_permit) & ~act_permit) == '0);

endmodule

// File: tb/act_win_limiter_bench.sv
module act_win_limiter_bench;

  localparam int NR     = 4;
  localparam int W      = 16;
  localparam int BUDGET = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          act_valid = 1'b0;
  logic [1:0]    act_rank = '0;
  logic [NR-1:0] act_permit, off_permit;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  string cur_req = "R1";
  int    hist [NR][$];

  always #5 clk = ~clk;

  act_win_limiter #(.NUM_RANKS(NR), .WINDOW(W), .ACT_BUDGET(BUDGET)) u_act_win_limiter (
    .clk(clk), .rst(rst), .act_valid(act_valid), .act_rank(act_rank),
    .act_permit(act_permit));

  act_win_limiter #(.NUM_RANKS(NR), .WINDOW(0), .ACT_BUDGET(BUDGET)) u_act_win_limiter_nowin (
    .clk(clk), .rst(rst), .act_valid(act_valid), .act_rank(act_rank),
    .act_permit(off_permit));

  // Reference: a list of activate times per rank, aged by arithmetic.
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int r = 0; r < NR; r++) hist[r].delete();
    end else begin
      for (int r = 0; r < NR; r++)
        while (hist[r].size() > 0 && cyc - hist[r][0] >= W) void'(hist[r].pop_front());
      if (act_valid && int'(act_rank) < NR) hist[act_rank].push_back(cyc);
    end
  end

  function automatic logic [NR-1:0] expect_permit();
    logic [NR-1:0] e;
    for (int r = 0; r < NR; r++) e[r] = (hist[r].size() < BUDGET);
    return e;
  endfunction

  task automatic compare();
    logic [NR-1:0] e;
    e = expect_permit();
    checks++;
    if (act_permit !== e) begin
      fails++;
      $display("FAIL %s cycle %0d: permit actual %b expected %b", cur_req, cyc, act_permit, e);
    end
    checks++;
    if (off_permit !== '1) begin
      fails++;
      $display("FAIL R7 cycle %0d: zero-window permit actual %b expected %b", cyc, off_permit, {NR{1'b1}});
    end
  endtask

  // Called at a negedge: drive, wait one cycle, compare at the next negedge.
  task automatic step(input logic v, input int r);
    act_valid = v;
    act_rank  = 2'(r);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0);
  endtask

  initial begin
    int guard;
    guard = 0;
    while (guard < 100000) begin
      @(posedge clk);
      guard++;
    end
    fails++;
    $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", guard);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    compare();                  // R1: permits high during reset
    rst = 1'b0;

    cur_req = "R3";             // four back-to-back on rank 0: blocked at the fourth
    for (int i = 0; i < 4; i++) step(1'b1, 0);
    cur_req = "R4";             // wait for expiry edge by edge
    idle(W);

    cur_req = "R5";             // keep activating while blocked
    for (int i = 0; i < 7; i++) step(1'b1, 1);
    idle(W + 2);

    cur_req = "R6";             // new activate lands on the expiry edge
    step(1'b1, 2);
    step(1'b1, 2);
    step(1'b1, 2);
    idle(W - 3);
    step(1'b1, 2);              // replaces the first one as it leaves
    step(1'b1, 2);
    step(1'b1, 2);
    idle(W + 1);

    cur_req = "R8";             // alternate ranks, only the hammered one blocks
    for (int i = 0; i < 10; i++) step(1'b1, (i % 2 == 0) ? 3 : i % 3);
    idle(W);

    cur_req = "R2";
    for (int i = 0; i < 5; i++) step(1'b1, 3);
    idle(4);

    cur_req = "R1";             // reset in the middle of a blocked state
    for (int i = 0; i < 4; i++) step(1'b1, 0);
    rst = 1'b1;
    step(1'b0, 0);
    rst = 1'b0;
    step(1'b1, 0);

    cur_req = "R3";             // pseudo-random traffic
    for (int i = 0; i < 3000; i++) step(($urandom % 3) != 0, int'($urandom % NR));
    idle(W + 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule